// File: doc/BRIEF.md
# Windowed Lookahead Input Scheduler

This block decides, for one time slot of an input-queued cell switch with `N_PORTS` inputs and `N_PORTS` outputs, which cell each input sends and where it goes. Every input shows the destination port of the first `WIN` cells waiting in its queue, each with a valid flag. A pulse on `start_i` captures these windows. The block then runs up to `WIN` contention rounds, one per clock cycle. In round 0 the head cells compete. In each later round, every input that has not yet won offers the next cell of its window. That cell may only compete for outputs that are still free in this slot.

When several inputs want the same free output in the same round, a round-robin pointer kept for that output picks the winner. The result is held, together with `done_o`, until the next `start_i`. The result gives, per input, a grant flag, the window position of the granted cell and the output reached, plus a map of the outputs taken. Queue storage, the crossbar and dequeue logic sit outside the block. `N_PORTS` must be a power of two and at least 2.

Top module: `wla_sched`

## Requirements
- R1: In one slot each output is granted to at most one input, and bit o of `out_busy_o` is set exactly when some granted input reports port o.
- R2: Round k (k = 0 .. WIN-1) considers only window position k of each input, and that cell requests its destination only when the destination was not taken in an earlier round of the slot.
- R3: An input granted in some round makes no request in any later round of the same slot; each input receives at most one grant per slot.
- R4: Among inputs requesting the same free output in a round, the winner is the first requester found scanning upward (wrapping) from that output's pointer. The pointer then becomes winner+1 modulo N_PORTS. A pointer is left unchanged in any round in which its output grants nothing.
- R5: A window entry whose valid bit is 0 makes no request; that input takes part again in the next round with its next position.
- R6: `start_i` sampled high while idle or done begins a slot; `done_o` rises R clock cycles after that edge. R is the smallest round count after which every input is granted or every output is busy, and at most WIN.
- R7: Window inputs are captured at the start edge; later changes to them do not alter the slot. Grants, positions, ports and the busy map stay unchanged while `done_o` is high until the next start.
- R8: With WIN = 1 the block grants only head cells, in a single round, as a plain head-of-line FIFO scheduler with round-robin output arbitration.
- R9: After reset `done_o` is low, no grant or busy bit is set, and every output pointer is 0.
- R10: Layout: the destination of input i, window position k is `win_dest_i[(i*WIN+k)*PW +: PW]` and its valid bit is `win_vld_i[i*WIN+k]`. The window position granted to input i is `gnt_pos_o[i*IW +: IW]` and its output port is `gnt_port_o[i*PW +: PW]`. PW = log2(N_PORTS) and IW = max(1, ceil(log2 WIN)).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a slot (accepted while idle or done) |
| win_dest_i | input | N_PORTS*WIN*PW | Destination port of each window entry |
| win_vld_i | input | N_PORTS*WIN | Valid flag of each window entry |
| done_o | output | 1 | Slot result ready and held |
| gnt_o | output | N_PORTS | Per-input grant flag |
| gnt_pos_o | output | N_PORTS*IW | Per-input granted window position |
| gnt_port_o | output | N_PORTS*PW | Per-input granted output port |
| out_busy_o | output | N_PORTS | Per-output taken map |

## Verification
The bench builds two copies side by side, both with four ports: one with a window of three and one with a window of one. Both copies get the same head cells, so the lookahead path and the plain head-of-line case are compared slot by slot. Four ports and three positions are small enough that directed patterns reach every corner: all inputs fighting for one output, empty windows, grants only at the last position, and early finish after the first round. Several hundred random slots then sweep pointer rotation, while a bench model of the round rule carries its own pointer state across slots.

// File: rtl/wla_pkg.sv
package wla_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } wla_state_e;
endpackage

// File: rtl/wla_req_sel.sv
// Forms the request of one input for the current round: one-hot over outputs.
module wla_req_sel #(
    parameter int N_PORTS = 4,
    parameter int WIN     = 3,
    parameter int PW      = 2,
    parameter int IW      = 2
) (
    input  logic              active_i,
    input  logic [WIN*PW-1:0] dest_row_i,
    input  logic [WIN-1:0]    vld_row_i,
    input  logic [IW-1:0]     rnd_i,
    input  logic [N_PORTS-1:0] busy_i,
    output logic [N_PORTS-1:0] req_o
);
    logic [PW-1:0] sel;

    always_comb begin
        req_o = '0;
        sel   = dest_row_i[rnd_i*PW +: PW];
        // invalid entries and taken outputs never request (R5, R2)
        if (active_i && vld_row_i[rnd_i]) begin
            req_o[sel] = !busy_i[sel];
        end
    end
endmodule

// File: rtl/wla_rr_arb.sv
// Round-robin arbiter for one output; pointer kept locally.
module wla_rr_arb #(
    parameter int N_REQ = 4,
    parameter int PW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    input  logic             upd_i,
    output logic [N_REQ-1:0] gnt_o,
    output logic             any_o
);
    logic [PW-1:0] ptr_q, ptr_d;
    logic [PW-1:0] idx;
    logic [PW-1:0] winner;

    always_comb begin
        gnt_o  = '0;
        any_o  = 1'b0;
        winner = '0;
        idx    = '0;
        for (int j = 0; j < N_REQ; j++) begin
            idx = ptr_q + PW'(j);
            if (!any_o && req_i[idx]) begin
                any_o  = 1'b1;
                winner = idx;
            end
        end
        gnt_o[winner] = any_o;
        ptr_d = (upd_i && any_o) ? winner + PW'(1) : ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assert_gnt_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_i && any_o) |=> $stable(ptr_q));
endmodule

// File: rtl/wla_sched.sv
module wla_sched #(
    parameter  int N_PORTS = 4,
    parameter  int WIN     = 3,
    localparam int PW      = $clog2(N_PORTS),
    localparam int IW      = (WIN > 1) ? $clog2(WIN) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [N_PORTS*WIN*PW-1:0] win_dest_i,
    input  logic [N_PORTS*WIN-1:0]    win_vld_i,
    output logic                      done_o,
    output logic [N_PORTS-1:0]        gnt_o,
    output logic [N_PORTS*IW-1:0]     gnt_pos_o,
    output logic [N_PORTS*PW-1:0]     gnt_port_o,
    output logic [N_PORTS-1:0]        out_busy_o
);
    import wla_pkg::*;

    localparam logic [IW-1:0] LAST_RND = IW'(WIN - 1);

    typedef struct packed {
        wla_state_e                st;
        logic [IW-1:0]             rnd;
        logic [N_PORTS-1:0]        gnt;
        logic [N_PORTS*IW-1:0]     pos;
        logic [N_PORTS*PW-1:0]     port;
        logic [N_PORTS-1:0]        busy;
        logic [N_PORTS*WIN*PW-1:0] dest;
        logic [N_PORTS*WIN-1:0]    vld;
    } slot_t;

    slot_t s_q, s_d;

    logic                            run;
    logic [N_PORTS-1:0][N_PORTS-1:0] req_by_in;
    logic [N_PORTS-1:0][N_PORTS-1:0] req_by_out;
    logic [N_PORTS-1:0][N_PORTS-1:0] arb_gnt;
    logic [N_PORTS-1:0]              arb_any;

    assign run = (s_q.st == ST_RUN);

    for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_in
        wla_req_sel #(.N_PORTS(N_PORTS), .WIN(WIN), .PW(PW), .IW(IW)) u_sel (
            .active_i  (run && !s_q.gnt[gi]),
            .dest_row_i(s_q.dest[gi*WIN*PW +: WIN*PW]),
            .vld_row_i (s_q.vld[gi*WIN +: WIN]),
            .rnd_i     (s_q.rnd),
            .busy_i    (s_q.busy),
            .req_o     (req_by_in[gi])
        );
    end

    always_comb begin
        for (int o = 0; o < N_PORTS; o++) begin
            for (int i = 0; i < N_PORTS; i++) begin
                req_by_out[o][i] = req_by_in[i][o];
            end
        end
    end

    for (genvar go = 0; go < N_PORTS; go++) begin : g_out
        wla_rr_arb #(.N_REQ(N_PORTS), .PW(PW)) u_arb (
            .clk  (clk),
            .rst_n(rst_n),
            .req_i(req_by_out[go]),
            .upd_i(run),
            .gnt_o(arb_gnt[go]),
            .any_o(arb_any[go])
        );
    end

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_RUN: begin
                for (int o = 0; o < N_PORTS; o++) begin
                    if (arb_any[o]) s_d.busy[o] = 1'b1;
                    for (int i = 0; i < N_PORTS; i++) begin
                        if (arb_gnt[o][i]) begin
                            s_d.gnt[i]            = 1'b1;
                            s_d.pos[i*IW +: IW]   = s_q.rnd;
                            s_d.port[i*PW +: PW]  = PW'(o);
                        end
                    end
                end
                if (s_q.rnd == LAST_RND || (&s_d.gnt) || (&s_d.busy)) begin
                    s_d.st = ST_DONE;
                end else begin
                    s_d.rnd = s_q.rnd + IW'(1);
                end
            end
            default: begin
                if (start_i) begin
                    s_d.st   = ST_RUN;
                    s_d.rnd  = '0;
                    s_d.gnt  = '0;
                    s_d.pos  = '0;
                    s_d.port = '0;
                    s_d.busy = '0;
                    s_d.dest = win_dest_i;
                    s_d.vld  = win_vld_i;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o     = (s_q.st == ST_DONE);
    assign gnt_o      = s_q.gnt;
    assign gnt_pos_o  = s_q.pos;
    assign gnt_port_o = s_q.port;
    assign out_busy_o = s_q.busy;

    assert_busy_mono_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ((s_q.busy & $past(s_q.busy)) == $past(s_q.busy)));

    assert_count_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s_q.gnt) == $countones(s_q.busy));

    assert_gnt_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ((s_q.gnt & $past(s_q.gnt)) == $past(s_q.gnt)));

    assert_round_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (s_q.rnd <= LAST_RND));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(gnt_o) && $stable(gnt_pos_o)
                                  && $stable(gnt_port_o) && $stable(out_busy_o)));
endmodule

// File: tb/test_wla_sched.sv
`timescale 1ns/1ps
module test_wla_sched;
    localparam int N  = 4;
    localparam int W  = 3;
    localparam int PW = 2;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N*W*PW-1:0] dest3 = '0;
    logic [N*W-1:0]    vld3  = '0;
    logic [N*PW-1:0]   dest1 = '0;
    logic [N-1:0]      vld1  = '0;

    logic              done3, done1;
    logic [N-1:0]      gnt3, gnt1, busy3, busy1;
    logic [N*IW-1:0]   pos3;
    logic [N-1:0]      pos1;
    logic [N*PW-1:0]   port3, port1;

    always #4 clk = ~clk;

    wla_sched #(.N_PORTS(N), .WIN(W)) i_wla_sched (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .win_dest_i(dest3), .win_vld_i(vld3),
        .done_o(done3), .gnt_o(gnt3), .gnt_pos_o(pos3),
        .gnt_port_o(port3), .out_busy_o(busy3)
    );

    wla_sched #(.N_PORTS(N), .WIN(1)) i_wla_sched_w1 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .win_dest_i(dest1), .win_vld_i(vld1),
        .done_o(done1), .gnt_o(gnt1), .gnt_pos_o(pos1),
        .gnt_port_o(port1), .out_busy_o(busy1)
    );

    int checks = 0;
    int fails  = 0;
    int s_dest[N][W];
    bit s_vld[N][W];
    int m_ptr[2][N];
    int e_gnt[2][N];
    int e_pos[2][N];
    int e_port[2][N];
    int e_busy[2][N];
    int e_rnd[2];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // round-by-round reference: s selects pointer set, w is window size
    task automatic model(input int s, input int w);
        int want[N];
        int win[N];
        int all_g, all_b;
        for (int i = 0; i < N; i++) begin
            e_gnt[s][i] = 0; e_pos[s][i] = 0; e_port[s][i] = 0; e_busy[s][i] = 0;
        end
        e_rnd[s] = 0;
        for (int k = 0; k < w; k++) begin
            e_rnd[s] = k + 1;
            for (int i = 0; i < N; i++) begin
                want[i] = -1;
                if (e_gnt[s][i] == 0 && s_vld[i][k] && e_busy[s][s_dest[i][k]] == 0)
                    want[i] = s_dest[i][k];
            end
            for (int o = 0; o < N; o++) begin
                win[o] = -1;
                for (int j = 0; j < N; j++) begin
                    int ii;
                    ii = (m_ptr[s][o] + j) % N;
                    if (want[ii] == o) begin
                        win[o] = ii;
                        break;
                    end
                end
            end
            for (int o = 0; o < N; o++) begin
                if (win[o] >= 0) begin
                    e_gnt[s][win[o]]  = 1;
                    e_pos[s][win[o]]  = k;
                    e_port[s][win[o]] = o;
                    e_busy[s][o]      = 1;
                    m_ptr[s][o]       = (win[o] + 1) % N;
                end
            end
            all_g = 1; all_b = 1;
            for (int i = 0; i < N; i++) begin
                if (e_gnt[s][i] == 0) all_g = 0;
                if (e_busy[s][i] == 0) all_b = 0;
            end
            if (all_g == 1 || all_b == 1) break;
        end
    endtask

    task automatic pack_in();
        for (int i = 0; i < N; i++) begin
            for (int k = 0; k < W; k++) begin
                dest3[(i*W+k)*PW +: PW] = PW'(s_dest[i][k]);
                vld3[i*W+k]             = s_vld[i][k];
            end
            dest1[i*PW +: PW] = PW'(s_dest[i][0]);
            vld1[i]           = s_vld[i][0];
        end
    endtask

    task automatic scramble();
        dest3 = (N*W*PW)'($urandom());
        vld3  = (N*W)'($urandom());
        dest1 = (N*PW)'($urandom());
        vld1  = N'($urandom());
    endtask

    task automatic check_outs(input int s, input string tag);
        int ag, ap, apt, ab;
        for (int i = 0; i < N; i++) begin
            ag  = (s == 0) ? int'(gnt3[i]) : int'(gnt1[i]);
            ap  = (s == 0) ? int'(pos3[i*IW +: IW]) : int'(pos1[i]);
            apt = (s == 0) ? int'(port3[i*PW +: PW]) : int'(port1[i*PW +: PW]);
            ab  = (s == 0) ? int'(busy3[i]) : int'(busy1[i]);
            chk(ag == e_gnt[s][i], {tag, " grant flag"}, ag, e_gnt[s][i]);
            if (e_gnt[s][i] == 1 && ag == 1) begin
                chk(ap == e_pos[s][i], {tag, " R10 window position"}, ap, e_pos[s][i]);
                chk(apt == e_port[s][i], {tag, " R10 output port"}, apt, e_port[s][i]);
            end
            chk(ab == e_busy[s][i], {tag, " R1 busy bit"}, ab, e_busy[s][i]);
        end
        // R1: granted inputs never share a port
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                int gi, gj, pi, pj;
                gi = (s == 0) ? int'(gnt3[i]) : int'(gnt1[i]);
                gj = (s == 0) ? int'(gnt3[j]) : int'(gnt1[j]);
                pi = (s == 0) ? int'(port3[i*PW +: PW]) : int'(port1[i*PW +: PW]);
                pj = (s == 0) ? int'(port3[j*PW +: PW]) : int'(port1[j*PW +: PW]);
                if (gi == 1 && gj == 1) chk(pi != pj, "R1 output granted twice", pi, -1);
            end
        end
    endtask

    task automatic run_slot();
        int c0, c1;
        model(0, W);
        model(1, 1);
        pack_in();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        scramble(); // R7: captured windows must not follow these changes
        c0 = -1; c1 = -1;
        for (int cnt = 0; cnt < 12; cnt++) begin
            if (c0 < 0 && done3) c0 = cnt;
            if (c1 < 0 && done1) c1 = cnt;
            if (c0 >= 0 && c1 >= 0) break;
            @(negedge clk);
        end
        chk(c0 == e_rnd[0], "R6 rounds to done (window 3)", c0, e_rnd[0]);
        chk(c1 == e_rnd[1], "R6 R8 rounds to done (window 1)", c1, e_rnd[1]);
        check_outs(0, "R2 R3 R4 R5");
        check_outs(1, "R8");
        scramble();
        repeat (2) @(negedge clk);
        check_outs(0, "R7 hold");
        check_outs(1, "R7 hold");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < 2; s++)
            for (int o = 0; o < N; o++) m_ptr[s][o] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(done3 == 1'b0 && done1 == 1'b0, "R9 done after reset", int'(done3), 0);
        chk(gnt3 == '0 && gnt1 == '0, "R9 grants after reset", int'(gnt3), 0);
        chk(busy3 == '0 && busy1 == '0, "R9 busy after reset", int'(busy3), 0);

        // identity: all matched in round 0 (R6 early finish)
        for (int i = 0; i < N; i++)
            for (int k = 0; k < W; k++) begin s_dest[i][k] = i; s_vld[i][k] = 1; end
        run_slot();

        // head cells all collide on output 2, later positions spread (R2)
        for (int i = 0; i < N; i++) begin
            s_dest[i][0] = 2; s_dest[i][1] = i; s_dest[i][2] = (i + 1) % N;
            for (int k = 0; k < W; k++) s_vld[i][k] = 1;
        end
        run_slot();

        // empty windows: no grants, full W rounds (R5)
        for (int i = 0; i < N; i++)
            for (int k = 0; k < W; k++) begin s_dest[i][k] = 0; s_vld[i][k] = 0; end
        run_slot();

        // only the last position valid (R5)
        for (int i = 0; i < N; i++) begin
            s_vld[i][0] = 0; s_vld[i][1] = 0; s_vld[i][2] = 1;
            s_dest[i][2] = N - 1 - i;
        end
        run_slot();

        // hot spot: every cell wants output 1, pointer rotates (R4)
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < N; i++)
                for (int k = 0; k < W; k++) begin s_dest[i][k] = 1; s_vld[i][k] = 1; end
            run_slot();
        end

        // random sweep
        for (int r = 0; r < 500; r++) begin
            for (int i = 0; i < N; i++)
                for (int k = 0; k < W; k++) begin
                    s_dest[i][k] = $urandom_range(0, N - 1);
                    s_vld[i][k]  = ($urandom_range(0, 3) != 0);
                end
            run_slot();
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule